// File: doc/BRIEF.md
# Shift, Swap and Width-Conversion Unit

This block is the shift and conversion slice of a small microcontroller core whose general registers are 24 bits wide. Each cycle it may accept one operation. The operation is one of three shifts, a byte swap inside the low 16 bits, or a width conversion. The conversions cover sign extension from 8 or 16 bits, narrowing from 32 bits, and the high half of a widening to 32 bits. The result and a write-enable for the destination register appear one clock later.

A shift works on the destination operand. Its distance is taken either from the full 24-bit source register value or from a 7-bit immediate. Swap and the conversions work on the source operand.

A 32-bit quantity is kept in a register pair. The low register holds bits 23:0. The low byte of the high register holds bits 31:24. When such a word goes to memory, its top 8 bits are written as zero. When it is read back, those bits are dropped. The widening operations therefore produce only the high register. The low register is the source value unchanged.

Top module: `svc_unit`

## Requirements
- R1: With `op_i`=0 (logical right shift) and a count below 24, `result_o` is `dst_i` shifted right with zeros entering at bit 23.
- R2: With `op_i`=1 (arithmetic right shift) and a count below 24, `result_o` is `dst_i` shifted right with copies of bit 23 entering.
- R3: With `op_i`=2 (logical left shift) and a count below 24, `result_o` is `dst_i` shifted left with zeros entering at bit 0, truncated to 24 bits.
- R4: A count of 24 or more gives zero for `op_i`=0 and `op_i`=2, and gives 24 copies of `dst_i[23]` for `op_i`=1.
- R5: With `use_imm_i`=1 the count is the 7-bit `imm_i` (0 to 127). With `use_imm_i`=0 the count is the whole 24-bit `src_i` value.
- R6: With `op_i`=3 (swap), `result_o[7:0]` = `src_i[15:8]`, `result_o[15:8]` = `src_i[7:0]`, and `result_o[23:16]` = 0.
- R7: With `op_i`=4, `result_o` is `src_i[7:0]` sign-extended to 24 bits.
- R8: With `op_i`=5, `result_o` is `src_i[15:0]` sign-extended to 24 bits.
- R9: With `op_i`=6 (32-to-24 narrowing), `result_o` = `src_i`, which is the low 24 bits of the pair.
- R10: With `op_i`=7 (high register of a 24-to-32 widening), every bit of `result_o` equals `src_i[23]`.
- R11: With `op_i`=8 (high register of a 16-to-32 widening), every bit of `result_o` equals `src_i[15]`.
- R12: Codes 9 to 15 of `op_i` are reserved. They give `wr_en_o`=0 and `result_o`=0.
- R13: Outputs are registered. The result of an operation presented with `valid_i`=1 appears exactly one rising edge later with `wr_en_o`=1. `valid_i`=0 gives `wr_en_o`=0 and `result_o`=0. Reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see R1 to R12) |
| use_imm_i | input | 1 | Shift count from immediate when 1, from source when 0 |
| dst_i | input | 24 | Destination register value, the shifted operand |
| src_i | input | 24 | Source register value |
| imm_i | input | 7 | Immediate shift count |
| result_o | output | 24 | Registered result |
| wr_en_o | output | 1 | Registered destination write-enable |

## Verification
Every result, including the reserved-code and idle responses, is due on the first rising edge after the inputs are presented. No operation takes longer than another. The bench drives the inputs on a falling edge and samples the outputs on the next falling edge, half a period after the capturing edge. Each sample is compared with a bench model of the requirements. Operations can be issued back to back, so each vector is checked before the next one replaces it. Reset values are sampled while reset is still asserted.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_SRL    = 4'd0;
  localparam logic [OP_W-1:0] OP_SRA    = 4'd1;
  localparam logic [OP_W-1:0] OP_SLL    = 4'd2;
  localparam logic [OP_W-1:0] OP_SWAP   = 4'd3;
  localparam logic [OP_W-1:0] OP_SX8    = 4'd4;
  localparam logic [OP_W-1:0] OP_SX16   = 4'd5;
  localparam logic [OP_W-1:0] OP_NARROW = 4'd6;
  localparam logic [OP_W-1:0] OP_HI24   = 4'd7;
  localparam logic [OP_W-1:0] OP_HI16   = 4'd8;
  localparam logic [OP_W-1:0] OP_LAST   = OP_HI16;

  typedef enum logic [1:0] {
    SH_RIGHT_LOG = 2'd0,
    SH_RIGHT_ARI = 2'd1,
    SH_LEFT_LOG  = 2'd2,
    SH_NONE      = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/svc_shift_core.sv
module svc_shift_core
  import svc_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  shift_kind_e       kind_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] count_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned STAGES = $clog2(DATA_W);

  logic              left;
  logic              fill;
  logic              saturate;
  logic [DATA_W-1:0] pre;
  logic [DATA_W-1:0] post;
  logic [DATA_W-1:0] stage [STAGES+1];

  assign left     = (kind_i == SH_LEFT_LOG);
  assign fill     = (kind_i == SH_RIGHT_ARI) & operand_i[DATA_W-1];
  assign saturate = (count_i >= DATA_W[DATA_W-1:0]);

  // left shift runs through the right shifter on the bit-reversed operand
  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      pre[b] = left ? operand_i[DATA_W-1-b] : operand_i[b];
    end
  end

  assign stage[0] = pre;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stage[s+1] = count_i[s]
                      ? {{SH{fill}}, stage[s][DATA_W-1:SH]}
                      : stage[s];
  end

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      post[b] = left ? stage[STAGES][DATA_W-1-b] : stage[STAGES][b];
    end
  end

  always_comb begin
    if (kind_i == SH_NONE) result_o = '0;
    else if (saturate)     result_o = {DATA_W{fill}};
    else                   result_o = post;
  end
endmodule

// File: rtl/svc_conv_core.sv
module svc_conv_core
  import svc_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned HI_W8  = DATA_W - 8;
  localparam int unsigned HI_W16 = DATA_W - 16;

  always_comb begin
    unique case (op_i)
      OP_SWAP:   result_o = {{HI_W16{1'b0}}, src_i[7:0], src_i[15:8]};
      OP_SX8:    result_o = {{HI_W8{src_i[7]}}, src_i[7:0]};
      OP_SX16:   result_o = {{HI_W16{src_i[15]}}, src_i[15:0]};
      OP_NARROW: result_o = src_i;
      OP_HI24:   result_o = {DATA_W{src_i[DATA_W-1]}};
      OP_HI16:   result_o = {DATA_W{src_i[15]}};
      default:   result_o = '0;
    endcase
  end
endmodule

// File: rtl/svc_unit.sv
module svc_unit
  import svc_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned IMM_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o
);
  logic [DATA_W-1:0] count;
  shift_kind_e       kind;
  logic              is_shift;
  logic              legal;
  logic [DATA_W-1:0] shift_res;
  logic [DATA_W-1:0] conv_res;
  logic [DATA_W-1:0] next_res;

  assign count    = use_imm_i ? {{(DATA_W-IMM_W){1'b0}}, imm_i} : src_i;
  assign is_shift = (op_i <= OP_SLL);
  assign legal    = (op_i <= OP_LAST);
  assign kind     = is_shift ? shift_kind_e'(op_i[1:0]) : SH_NONE;

  svc_shift_core #(.DATA_W(DATA_W)) shift_i (
    .kind_i   (kind),
    .operand_i(dst_i),
    .count_i  (count),
    .result_o (shift_res)
  );

  svc_conv_core #(.DATA_W(DATA_W)) conv_i (
    .op_i    (op_i),
    .src_i   (src_i),
    .result_o(conv_res)
  );

  always_comb begin
    if (!valid_i || !legal) next_res = '0;
    else if (is_shift)      next_res = shift_res;
    else                    next_res = conv_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      result_o <= next_res;
      wr_en_o  <= valid_i & legal;
    end
  end

  // R13
  wr_en_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i));

  // R12
  reserved_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) > OP_LAST) |-> (!wr_en_o && result_o == '0));

  // R4
  big_left_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) == OP_SLL && $past(count) >= DATA_W)
    |-> result_o == '0);

  // R6
  swap_top_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) == OP_SWAP)
    |-> (result_o[DATA_W-1:16] == '0 && result_o[7:0] == $past(src_i[15:8])));

  // R10
  hi24_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && $past(op_i) == OP_HI24)
    |-> ($countones(result_o) == 0 || $countones(result_o) == DATA_W));
endmodule

// File: tb/svc_unit_tb.sv
module svc_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RANDOM   = 3000;
  localparam int  WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        use_imm_i = 1'b0;
  logic [23:0] dst_i = '0;
  logic [23:0] src_i = '0;
  logic [6:0]  imm_i = '0;
  logic [23:0] result_o;
  logic        wr_en_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  svc_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .use_imm_i,
    .dst_i, .src_i, .imm_i, .result_o, .wr_en_o
  );

  function automatic logic [23:0] model(input logic v, input logic [3:0] op,
      input logic ui, input logic [23:0] d, input logic [23:0] s, input logic [6:0] im);
    int unsigned cnt;
    logic [31:0] wide;
    cnt = ui ? int'(im) : int'(s);
    if (!v) return 24'h0;
    case (op)
      4'd0: return (cnt >= 24) ? 24'h0 : d >> cnt;
      4'd1: begin
        wide = {{8{d[23]}}, d};
        if (cnt >= 24) cnt = 31;
        wide = 32'($signed(wide) >>> cnt);
        return wide[23:0];
      end
      4'd2: return (cnt >= 24) ? 24'h0 : 24'(d << cnt);
      4'd3: return {8'h00, s[7:0], s[15:8]};
      4'd4: return {{16{s[7]}}, s[7:0]};
      4'd5: return {{8{s[15]}}, s[15:0]};
      4'd6: return s;
      4'd7: return s[23] ? 24'hFFFFFF : 24'h0;
      4'd8: return s[15] ? 24'hFFFFFF : 24'h0;
      default: return 24'h0;
    endcase
  endfunction

  function automatic string req_of(input logic v, input logic [3:0] op,
      input logic ui, input logic [23:0] s, input logic [6:0] im);
    int unsigned cnt;
    cnt = ui ? int'(im) : int'(s);
    if (!v) return "R13";
    if (op <= 4'd2 && cnt >= 24) return "R4";
    case (op)
      4'd0: return ui ? "R1" : "R1/R5";
      4'd1: return ui ? "R2" : "R2/R5";
      4'd2: return ui ? "R3" : "R3/R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic run(input logic v, input logic [3:0] op, input logic ui,
      input logic [23:0] d, input logic [23:0] s, input logic [6:0] im);
    logic [23:0] exp_r;
    logic        exp_w;
    string       rq;
    @(negedge clk_i);
    valid_i = v; op_i = op; use_imm_i = ui; dst_i = d; src_i = s; imm_i = im;
    exp_r = model(v, op, ui, d, s, im);
    exp_w = v && (op <= 4'd8);
    rq = req_of(v, op, ui, s, im);
    @(negedge clk_i);
    total++;
    if (result_o !== exp_r || wr_en_o !== exp_w) begin
      bad++;
      $display("FAIL %s op=%0d result=%h/%b expected=%h/%b",
               rq, op, result_o, wr_en_o, exp_r, exp_w);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog expired result=%h expected=done", result_o);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R13 reset state
    repeat (2) @(negedge clk_i);
    total++;
    if (result_o !== 24'h0 || wr_en_o !== 1'b0) begin
      bad++;
      $display("FAIL R13 reset result=%h/%b expected=000000/0", result_o, wr_en_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 R2 R3 directed
    run(1, 4'd0, 1, 24'h800001, 0, 7'd1);
    run(1, 4'd1, 1, 24'h800001, 0, 7'd1);
    run(1, 4'd1, 1, 24'h812345, 0, 7'd23);
    run(1, 4'd2, 1, 24'h000001, 0, 7'd23);
    run(1, 4'd2, 1, 24'hABCDEF, 0, 7'd0);
    // R4 boundaries
    run(1, 4'd0, 1, 24'hFFFFFF, 0, 7'd24);
    run(1, 4'd1, 1, 24'h800000, 0, 7'd24);
    run(1, 4'd1, 1, 24'h7FFFFF, 0, 7'd127);
    run(1, 4'd2, 1, 24'hFFFFFF, 0, 7'd24);
    // R5 count from whole source value
    run(1, 4'd0, 0, 24'hF00000, 24'h000004, 7'd0);
    run(1, 4'd0, 0, 24'hF00000, 24'h010001, 7'd1);
    run(1, 4'd1, 0, 24'h900000, 24'h000080, 7'd1);
    // R6..R11
    run(1, 4'd3, 0, 0, 24'hFF1234, 0);
    run(1, 4'd4, 0, 0, 24'h123480, 0);
    run(1, 4'd4, 0, 0, 24'hFFFF7F, 0);
    run(1, 4'd5, 0, 0, 24'h128000, 0);
    run(1, 4'd6, 0, 0, 24'hA5C3E1, 0);
    run(1, 4'd7, 0, 0, 24'h800000, 0);
    run(1, 4'd7, 0, 0, 24'h7FFFFF, 0);
    run(1, 4'd8, 0, 0, 24'h008000, 0);
    run(1, 4'd8, 0, 0, 24'hFF7FFF, 0);
    // R12 reserved, R13 idle
    run(1, 4'd9, 0, 24'hFFFFFF, 24'hFFFFFF, 7'd3);
    run(1, 4'd15, 1, 24'hFFFFFF, 24'hFFFFFF, 7'd3);
    run(0, 4'd3, 0, 24'hFFFFFF, 24'hFFFFFF, 7'd3);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [3:0]  op;
      logic [23:0] s;
      op = 4'($urandom_range(0, 15));
      s  = 24'($urandom());
      if ($urandom_range(0, 3) != 0) s = s % 30;
      run($urandom_range(0, 9) != 0, op, 1'($urandom()), 24'($urandom()), s,
          7'($urandom_range(0, 40)));
    end
    summary();
  end
endmodule